// File: doc/BRIEF.md
# Byte-Lane Selected Static Memory

This block is a synthesizable model of a wide static memory whose 24-bit word is split into three 8-bit lanes. Each lane has its own active-low select. A lane whose select is low takes part in the current access, and a lane whose select is high is left alone. Write enable and output enable are shared by all lanes. Output enable only matters for reads. During a write it has no effect.

The storage array is clocked by a simulation clock. Inputs are sampled on each rising edge, and the read data, the per-lane output-enable vector and the standby flag all appear one clock later. The output-enable vector stands in for tri-state pins: a lane whose enable bit is low is treated as high impedance, and its data bits read as zero.

The address width is a parameter. Set it to 19 for the full 512K-word depth. The default is a small array so that a testbench can reach every lane combination quickly.

Top module: `lane_sram`

## Requirements
- R1: On a rising edge where lane i's select is low and write enable is low, lane i of the addressed word takes wrData bits [8i+7:8i]. Lane 0 is bits 7:0, lane 1 is bits 15:8 and lane 2 is bits 23:16. Lanes whose select is high keep their stored value.
- R2: On a rising edge where lane i's select is low, write enable is high and output enable is low, outEn[i] is 1 after that edge and rdData lane i holds the stored value of the addressed word. With all three selects low, all 24 bits are returned.
- R3: During a write, output enable has no effect on what is stored. Every lane selected for the write has its outEn bit at 0 after that edge.
- R4: When output enable is high during a read (write enable high), every outEn bit is 0 after that edge, even though lanes are selected.
- R5: Any lane whose outEn bit is 0 drives 0 on its eight rdData bits.
- R6: standby is 1 after an edge where all three selects are high, and 0 after an edge where any select is low. This includes the case where lanes are selected but their outputs are disabled.
- R7: A write held for several edges, with the data changing between edges, leaves the data from the last edge before the write ends. The write may end by write enable rising or by the select rising.
- R8: While rstN is low, outEn is 0, rdData is 0 and standby is 1. The stored array contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Simulation clock; inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the output registers |
| addr | input | ADDR_W | Word address |
| selN | input | 3 | Active-low lane selects, bit i governs lane i |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable; has no effect during writes |
| wrData | input | 24 | Write data, lane i on bits [8i+7:8i] |
| rdData | output | 24 | Read data, registered; a disabled lane reads 0 |
| outEn | output | 3 | Per-lane output enable standing in for tri-state drive |
| standby | output | 1 | High when the last sampled selects were all high |

## Verification
Every one of the eight lane-select masks is used for writes over a known full-word background. This separates a lane that is written from one that is wrongly written or wrongly left alone. Every mask is also used for reads, which confirms that the enable vector and the zeroed disabled lanes follow the mask exactly. Writes are issued with output enable both low and high, which shows that it is ignored. Reads with output enable high are checked against standby, which keeps "selected but quiet" apart from "deselected". Held writes whose data changes, ended once by write enable and once by the select, show that the last sampled data is the one kept.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

  localparam int LANES  = 3;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  // Strobes passed from control to datapath for one sampled cycle.
  typedef struct packed {
    logic [LANES-1:0] wrLane;   // lanes committing a write this edge
    logic [LANES-1:0] rdLane;   // lanes presenting read data after this edge
    logic             allOff;   // every select is high
  } laneStrobe_t;

endpackage

// File: rtl/lane_sram_ctrl.sv
module lane_sram_ctrl
  import lane_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] selN,
  input  logic             weN,
  input  logic             oeN,
  output laneStrobe_t      strobe,
  output logic             standby
);

  logic [LANES-1:0] picked;
  logic             writeMode;
  logic             readDrive;

  assign picked    = ~selN;
  assign writeMode = ~weN;
  // Output enable only counts while not writing.
  assign readDrive = weN & ~oeN;

  always_comb begin
    strobe        = '0;
    strobe.wrLane = picked & {LANES{writeMode}};
    strobe.rdLane = picked & {LANES{readDrive}};
    strobe.allOff = &selN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) standby <= 1'b1;
    else       standby <= strobe.allOff;
  end

endmodule

// File: rtl/lane_sram_dp.sv
module lane_sram_dp
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  laneStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData,
  output logic [LANES-1:0]  outEn
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] laneQ;
    logic              enQ;

    always_ff @(posedge clk) begin
      if (strobe.wrLane[g]) store[addr] <= wrData[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneQ <= '0;
        enQ   <= 1'b0;
      end else begin
        enQ   <= strobe.rdLane[g];
        laneQ <= strobe.rdLane[g] ? store[addr] : '0;
      end
    end

    assign rdData[g*LANE_W +: LANE_W] = laneQ;
    assign outEn[g]                   = enQ;
  end

endmodule

// File: rtl/lane_sram.sv
module lane_sram
  import lane_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  selN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [LANES-1:0]  outEn,
  output logic              standby
);

  laneStrobe_t strobe;

  lane_sram_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .selN    (selN),
    .weN     (weN),
    .oeN     (oeN),
    .strobe  (strobe),
    .standby (standby)
  );

  lane_sram_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .addr   (addr),
    .wrData (wrData),
    .strobe (strobe),
    .rdData (rdData),
    .outEn  (outEn)
  );

endmodule

// File: rtl/lane_sram_chk.sv
module lane_sram_chk
  import lane_sram_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [LANES-1:0]  selN,
  input logic              weN,
  input logic              oeN,
  input logic [DATA_W-1:0] rdData,
  input logic [LANES-1:0]  outEn,
  input logic              standby
);

  // Set once an edge has passed with reset released, so $past refers to live inputs.
  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLaneChk
    a_r2_drive_needs_read : assert property (@(posedge clk) disable iff (!rstN)
      (armed && outEn[g]) |-> ($past(selN[g]) == 1'b0 && $past(weN) && !$past(oeN)));

    a_r3_write_quiet : assert property (@(posedge clk) disable iff (!rstN)
      (!selN[g] && !weN) |=> !outEn[g]);

    a_r4_oe_high_quiet : assert property (@(posedge clk) disable iff (!rstN)
      (weN && oeN) |=> !outEn[g]);

    a_r5_idle_lane_zero : assert property (@(posedge clk) disable iff (!rstN)
      !outEn[g] |-> (rdData[g*LANE_W +: LANE_W] == '0));
  end

  a_r6_standby_tracks : assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (standby == $past(&selN)));

  a_r6_standby_no_drive : assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (outEn == '0));

endmodule

bind lane_sram lane_sram_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .selN    (selN),
  .weN     (weN),
  .oeN     (oeN),
  .rdData  (rdData),
  .outEn   (outEn),
  .standby (standby)
);

// File: tb/lane_sram_tb_top.sv
module lane_sram_tb_top;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic [2:0]    selN;
  logic          weN, oeN;
  logic [23:0]   wrData;
  logic [23:0]   rdData;
  logic [2:0]    outEn;
  logic          standby;

  int nChecks = 0;
  int nFails  = 0;
  logic [23:0] model [DEPTH];

  always #2 clk = ~clk;

  lane_sram #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .selN(selN), .weN(weN), .oeN(oeN),
    .wrData(wrData), .rdData(rdData), .outEn(outEn), .standby(standby)
  );

  function automatic logic [23:0] laneBits(input logic [2:0] m);
    return {{8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs on the falling edge, then settle past the next rising edge.
  task automatic step(input logic [AW-1:0] a, input logic [2:0] s, input logic w,
                      input logic o, input logic [23:0] d);
    @(negedge clk);
    addr = a; selN = s; weN = w; oeN = o; wrData = d;
    @(posedge clk);
    #1;
  endtask

  task automatic writeMasked(input logic [AW-1:0] a, input logic [2:0] m, input logic o,
                             input logic [23:0] d);
    step(a, ~m, 1'b0, o, d);
    model[a] = (model[a] & ~laneBits(m)) | (d & laneBits(m));
  endtask

  task automatic idle();
    step('0, 3'b111, 1'b1, 1'b1, 24'h0);
  endtask

  task automatic tReset();
    rstN = 1'b0; addr = '0; selN = 3'b000; weN = 1'b1; oeN = 1'b0; wrData = '0;
    repeat (3) @(posedge clk);
    #1;
    check(outEn == 3'b000, "R8 outEn in reset", {21'h0, outEn}, 24'h0);
    check(rdData == 24'h0, "R8 rdData in reset", rdData, 24'h0);
    check(standby == 1'b1, "R8 standby in reset", {23'h0, standby}, 24'h1);
    @(negedge clk);
    rstN = 1'b1;
    idle();
  endtask

  task automatic tFullWord();
    for (int i = 0; i < DEPTH; i++) writeMasked(i[AW-1:0], 3'b111, 1'b1, 24'hA50000 ^ (i * 24'h010203));
    for (int i = 0; i < DEPTH; i += 7) begin
      step(i[AW-1:0], 3'b000, 1'b1, 1'b0, 24'h0);
      check(outEn == 3'b111, "R2 full read enables", {21'h0, outEn}, 24'h7);
      check(rdData == model[i], "R1 R2 full word", rdData, model[i]);
    end
  endtask

  task automatic tLaneMasks();
    for (int m = 0; m < 8; m++) begin
      logic [AW-1:0] a;
      a = AW'(m + 3);
      writeMasked(a, 3'b111, 1'b1, 24'h5A5A5A);
      writeMasked(a, m[2:0], 1'b0, 24'hC3 * (m + 1) + 24'h123400);
      step(a, 3'b000, 1'b1, 1'b0, 24'h0);
      check(rdData == model[a], "R1 masked write result", rdData, model[a]);
      step(a, ~m[2:0], 1'b1, 1'b0, 24'h0);
      check(outEn == m[2:0], "R2 masked read enables", {21'h0, outEn}, {21'h0, m[2:0]});
      check(rdData == (model[a] & laneBits(m[2:0])), "R5 masked read data", rdData,
            model[a] & laneBits(m[2:0]));
    end
  endtask

  task automatic tWriteOe();
    writeMasked(6'd40, 3'b111, 1'b0, 24'h111111);
    check(outEn == 3'b000, "R3 no drive during write oe low", {21'h0, outEn}, 24'h0);
    writeMasked(6'd41, 3'b111, 1'b1, 24'h222222);
    check(outEn == 3'b000, "R3 no drive during write oe high", {21'h0, outEn}, 24'h0);
    check(rdData == 24'h0, "R5 data zero during write", rdData, 24'h0);
    step(6'd40, 3'b000, 1'b1, 1'b0, 24'h0);
    check(rdData == 24'h111111, "R3 write with oe low stored", rdData, 24'h111111);
    step(6'd41, 3'b000, 1'b1, 1'b0, 24'h0);
    check(rdData == 24'h222222, "R3 write with oe high stored", rdData, 24'h222222);
  endtask

  task automatic tOeHigh();
    step(6'd40, 3'b000, 1'b1, 1'b1, 24'h0);
    check(outEn == 3'b000, "R4 oe high read enables", {21'h0, outEn}, 24'h0);
    check(rdData == 24'h0, "R5 oe high read data", rdData, 24'h0);
    check(standby == 1'b0, "R6 selected but disabled is active", {23'h0, standby}, 24'h0);
  endtask

  task automatic tStandby();
    step(6'd40, 3'b111, 1'b1, 1'b0, 24'h0);
    check(standby == 1'b1, "R6 all deselected standby", {23'h0, standby}, 24'h1);
    check(outEn == 3'b000, "R6 standby no enables", {21'h0, outEn}, 24'h0);
    step(6'd40, 3'b101, 1'b1, 1'b0, 24'h0);
    check(standby == 1'b0, "R6 one select active", {23'h0, standby}, 24'h0);
    check(rdData == (24'h111111 & 24'h00FF00), "R2 middle lane only", rdData, 24'h001100);
  endtask

  task automatic tLongWrite();
    step(6'd50, 3'b000, 1'b0, 1'b1, 24'hAAAAAA);
    step(6'd50, 3'b000, 1'b0, 1'b1, 24'hBBBBBB);
    step(6'd50, 3'b000, 1'b0, 1'b1, 24'hCCCCCC);
    step(6'd50, 3'b000, 1'b1, 1'b1, 24'hDDDDDD);
    step(6'd50, 3'b000, 1'b1, 1'b0, 24'h0);
    check(rdData == 24'hCCCCCC, "R7 held write ended by write enable", rdData, 24'hCCCCCC);
    step(6'd51, 3'b000, 1'b0, 1'b1, 24'h123456);
    step(6'd51, 3'b000, 1'b0, 1'b1, 24'h654321);
    step(6'd51, 3'b111, 1'b0, 1'b1, 24'h999999);
    step(6'd51, 3'b000, 1'b1, 1'b0, 24'h0);
    check(rdData == 24'h654321, "R7 held write ended by select", rdData, 24'h654321);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 24'h0, 24'h1);
    finishRun();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    tReset();
    tFullWord();
    tLaneMasks();
    tWriteOe();
    tOeHigh();
    tStandby();
    tLongWrite();
    idle();
    finishRun();
  end

endmodule